// File: doc/BRIEF.md
# Touch Coordinate Scaler with Decimal Readout

This block turns a raw touch-sensor reading into a screen position. Each sample delivers a 12-bit horizontal and a 12-bit vertical converter value together with a one-cycle valid strobe. The block clamps each reading into its calibrated window and takes the distance from the window end that corresponds to screen coordinate zero. It then scales that distance onto an 800 by 600 pixel grid, using a fixed-point constant fixed at elaboration, a multiply and a 10-bit right shift. No divider is built.

The two axes run in opposite senses. The sensor counts upward from its bottom-left corner, while the screen counts downward from its top-left corner. For that reason the vertical axis measures its distance from the high end of its window. After scaling, each pixel coordinate is turned into three packed decimal digits, ready for a seven-segment decoder. A done pulse marks the cycle in which fresh digits appear.

Between samples, every output keeps the last converted position. The design is a short pipeline and can accept a new sample on every cycle.

Top module: `touch_pixel_conv`

## Requirements
- R1: While `rst` is high and after it falls with no sample, `pix_x`, `pix_y`, `dec_x` and `dec_y` are zero and `dec_done` is low.
- R2: Horizontal mapping: with c = adc_x clamped to [132, 3946] and o = c - 132, `pix_x` = min(799, (o * 215) >> 10), where 215 = ceil(799 * 1024 / 3814).
- R3: Vertical mapping is inverted: with c = adc_y clamped to [148, 3849] and o = 3849 - c, `pix_y` = min(599, (o * 166) >> 10), where 166 = ceil(599 * 1024 / 3701). A larger reading gives a smaller `pix_y`.
- R4: The window ends land exactly on the grid edges: adc_x 132 gives 0, adc_x 3946 gives 799, adc_y 3849 gives 0 and adc_y 148 gives 599.
- R5: A horizontal reading below 132 converts as 132, and one above 3946 converts as 3946.
- R6: A vertical reading below 148 converts as 148, and one above 3849 converts as 3849.
- R7: If `sample_vld` is high at clock edge E, the new `pix_x`/`pix_y` appear after edge E+1, and the new `dec_x`/`dec_y` appear after edge E+2, with `dec_done` high for exactly the cycle following E+2.
- R8: `dec_x` and `dec_y` hold the decimal value of the pixel coordinate: hundreds in bits [11:8], tens in bits [7:4], ones in bits [3:0], each digit 0 to 9.
- R9: While `sample_vld` is low, a change on `adc_x`/`adc_y` has no effect: the pixel and decimal outputs keep their last values and `dec_done` stays low.
- R10: Each converted coordinate is never below the ideal floor(o * pixel_span / adc_span) and never more than 2 above it.
- R11: Samples on consecutive cycles each give their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Strobe: the ADC values are valid this cycle |
| adc_x | input | 12 | Raw horizontal converter reading |
| adc_y | input | 12 | Raw vertical converter reading |
| pix_x | output | 10 | Last converted pixel column, 0 to 799 |
| pix_y | output | 10 | Last converted pixel row, 0 to 599 |
| dec_x | output | 12 | Three packed decimal digits of `pix_x` |
| dec_y | output | 12 | Three packed decimal digits of `pix_y` |
| dec_done | output | 1 | One-cycle pulse when new decimal digits are present |

## Verification
Each scenario drives its sample on a falling edge, so the capturing rising edge is known. The pixel results are then read on the falling edge after one more rising edge. The decimal digits and the done pulse are read one falling edge later, and `dec_done` is checked low again a cycle after that. For back-to-back samples, the checks read two results on consecutive cycles. The hold scenario changes the readings with the strobe low and reads the outputs on several later cycles.

// File: rtl/touch_pkg.sv
package touch_pkg;

    localparam int ADC_W     = 12;
    localparam int PIX_W     = 10;
    localparam int FRAC_BITS = 10;

    localparam int X_ADC_LO  = 132;
    localparam int X_ADC_HI  = 3946;
    localparam int X_PIX_MAX = 799;

    localparam int Y_ADC_LO  = 148;
    localparam int Y_ADC_HI  = 3849;
    localparam int Y_PIX_MAX = 599;

    // Rounded-up fixed-point slope so that a full-span offset reaches pix_max.
    function automatic int ceil_scale(int pix_max, int adc_span, int frac);
        return (pix_max * (1 << frac) + adc_span - 1) / adc_span;
    endfunction

    function automatic int dec_digits(int max_value);
        int n;
        int v;
        n = 1;
        v = max_value;
        while (v >= 10) begin
            v = v / 10;
            n = n + 1;
        end
        return n;
    endfunction

    localparam int PIX_MAX_ANY = (X_PIX_MAX > Y_PIX_MAX) ? X_PIX_MAX : Y_PIX_MAX;
    localparam int BCD_DIGITS  = dec_digits(PIX_MAX_ANY);
    localparam int BCD_W       = 4 * BCD_DIGITS;

    typedef enum logic { AXIS_RISING = 1'b0, AXIS_FALLING = 1'b1 } axis_dir_e;

    typedef struct packed {
        logic             vld;
        logic [ADC_W-1:0] off;
    } offset_stage_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
    } pixel_stage_t;

    // Shift-and-add-3 binary to packed decimal.
    function automatic logic [BCD_W-1:0] to_bcd(logic [PIX_W-1:0] bin);
        logic [BCD_W-1:0] acc;
        acc = '0;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            for (int d = 0; d < BCD_DIGITS; d++) begin
                if (acc[4*d +: 4] >= 4'd5)
                    acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
            end
            acc = {acc[BCD_W-2:0], bin[i]};
        end
        return acc;
    endfunction

endpackage

// File: rtl/touch_axis_scale.sv
module touch_axis_scale
    import touch_pkg::*;
#(
    parameter int        ADC_LO  = 132,
    parameter int        ADC_HI  = 3946,
    parameter int        PIX_MAX = 799,
    parameter axis_dir_e DIR     = AXIS_RISING
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ADC_W-1:0] adc,
    output logic             out_vld,
    output logic [PIX_W-1:0] pix
);
    localparam int SPAN   = ADC_HI - ADC_LO;
    localparam int K      = ceil_scale(PIX_MAX, SPAN, FRAC_BITS);
    localparam int K_W    = $clog2(K + 1);
    localparam int PROD_W = ADC_W + K_W;

    logic [ADC_W-1:0] adc_clamped;
    logic [ADC_W-1:0] offset_d;
    offset_stage_t    s1_q;
    pixel_stage_t     s2_q;
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] scaled;
    logic [PIX_W-1:0]  pix_sat;

    // Stage 1: clamp into the calibrated window and take the distance from the zero end.
    always_comb begin
        if (adc < ADC_W'(ADC_LO))
            adc_clamped = ADC_W'(ADC_LO);
        else if (adc > ADC_W'(ADC_HI))
            adc_clamped = ADC_W'(ADC_HI);
        else
            adc_clamped = adc;
    end

    generate
        if (DIR == AXIS_FALLING) begin : g_from_high
            assign offset_d = ADC_W'(ADC_HI) - adc_clamped;
        end else begin : g_from_low
            assign offset_d = adc_clamped - ADC_W'(ADC_LO);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_vld;
            if (in_vld)
                s1_q.off <= offset_d;
        end
    end

    // Stage 2: constant multiply, drop the fraction, saturate at the grid edge.
    assign product = PROD_W'(s1_q.off) * PROD_W'(K);
    assign scaled  = product >> FRAC_BITS;
    assign pix_sat = (scaled > PROD_W'(PIX_MAX)) ? PIX_W'(PIX_MAX) : PIX_W'(scaled);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.vld <= s1_q.vld;
            if (s1_q.vld)
                s2_q.pix <= pix_sat;
        end
    end

    assign out_vld = s2_q.vld;
    assign pix     = s2_q.pix;

    p_off_bound_r5: assert property (@(posedge clk) disable iff (rst)
        s1_q.vld |-> (s1_q.off <= ADC_W'(SPAN)));
    p_pix_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (pix <= PIX_W'(PIX_MAX)));
    p_low_end_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_q.vld && s1_q.off == '0) |=> (pix == '0));
    p_high_end_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_q.vld && s1_q.off == ADC_W'(SPAN)) |=> (pix == PIX_W'(PIX_MAX)));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !s1_q.vld |=> $stable(pix));

endmodule

// File: rtl/touch_bcd_stage.sv
module touch_bcd_stage
    import touch_pkg::*;
#(
    parameter int N_VAL = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_vld,
    input  logic [N_VAL-1:0][PIX_W-1:0] bin,
    output logic                        done,
    output logic [N_VAL-1:0][BCD_W-1:0] bcd
);
    logic [N_VAL-1:0][BCD_W-1:0] bcd_q;
    logic                        done_q;

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else
            done_q <= in_vld;
    end

    generate
        for (genvar v = 0; v < N_VAL; v++) begin : g_val
            always_ff @(posedge clk) begin
                if (rst)
                    bcd_q[v] <= '0;
                else if (in_vld)
                    bcd_q[v] <= to_bcd(bin[v]);
            end

            for (genvar d = 0; d < BCD_DIGITS; d++) begin : g_digit
                p_digit_range_r8: assert property (@(posedge clk) disable iff (rst)
                    done |-> (bcd_q[v][4*d +: 4] <= 4'd9));
            end

            p_bcd_hold_r9: assert property (@(posedge clk) disable iff (rst)
                !in_vld |=> $stable(bcd_q[v]));
        end
    endgenerate

    assign done = done_q;
    assign bcd  = bcd_q;

    p_done_follows_r7: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> done);
    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !done);

endmodule

// File: rtl/touch_pixel_conv.sv
module touch_pixel_conv
    import touch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_vld,
    input  logic [ADC_W-1:0] adc_x,
    input  logic [ADC_W-1:0] adc_y,
    output logic [PIX_W-1:0] pix_x,
    output logic [PIX_W-1:0] pix_y,
    output logic [BCD_W-1:0] dec_x,
    output logic [BCD_W-1:0] dec_y,
    output logic             dec_done
);
    localparam int N_AXES = 2;

    logic                         x_vld;
    logic                         y_vld;
    logic [N_AXES-1:0][PIX_W-1:0] pix_pair;
    logic [N_AXES-1:0][BCD_W-1:0] bcd_pair;

    touch_axis_scale #(
        .ADC_LO (X_ADC_LO),
        .ADC_HI (X_ADC_HI),
        .PIX_MAX(X_PIX_MAX),
        .DIR    (AXIS_RISING)
    ) u_axis_x (
        .clk    (clk),
        .rst    (rst),
        .in_vld (sample_vld),
        .adc    (adc_x),
        .out_vld(x_vld),
        .pix    (pix_x)
    );

    touch_axis_scale #(
        .ADC_LO (Y_ADC_LO),
        .ADC_HI (Y_ADC_HI),
        .PIX_MAX(Y_PIX_MAX),
        .DIR    (AXIS_FALLING)
    ) u_axis_y (
        .clk    (clk),
        .rst    (rst),
        .in_vld (sample_vld),
        .adc    (adc_y),
        .out_vld(y_vld),
        .pix    (pix_y)
    );

    assign pix_pair[0] = pix_x;
    assign pix_pair[1] = pix_y;

    touch_bcd_stage #(
        .N_VAL(N_AXES)
    ) u_bcd (
        .clk   (clk),
        .rst   (rst),
        .in_vld(x_vld & y_vld),
        .bin   (pix_pair),
        .done  (dec_done),
        .bcd   (bcd_pair)
    );

    assign dec_x = bcd_pair[0];
    assign dec_y = bcd_pair[1];

    p_axes_aligned_r11: assert property (@(posedge clk) disable iff (rst)
        x_vld == y_vld);
    p_done_after_pixel_r7: assert property (@(posedge clk) disable iff (rst)
        dec_done |-> $past(x_vld));

endmodule

// File: tb/touch_pixel_conv_tb.sv
module touch_pixel_conv_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_vld = 1'b0;
    logic [11:0] adc_x = '0;
    logic [11:0] adc_y = '0;
    logic [9:0]  pix_x;
    logic [9:0]  pix_y;
    logic [11:0] dec_x;
    logic [11:0] dec_y;
    logic        dec_done;

    int checks = 0;
    int failures = 0;
    int lcg = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_pixel_conv u_dut (
        .clk(clk), .rst(rst), .sample_vld(sample_vld),
        .adc_x(adc_x), .adc_y(adc_y),
        .pix_x(pix_x), .pix_y(pix_y),
        .dec_x(dec_x), .dec_y(dec_y), .dec_done(dec_done)
    );

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Reference per R2/R5
    function automatic int ref_x(int a);
        int c; int v;
        c = (a < 132) ? 132 : (a > 3946) ? 3946 : a;
        v = ((c - 132) * 215) / 1024;
        return (v > 799) ? 799 : v;
    endfunction

    // Reference per R3/R6
    function automatic int ref_y(int a);
        int c; int v;
        c = (a < 148) ? 148 : (a > 3849) ? 3849 : a;
        v = ((3849 - c) * 166) / 1024;
        return (v > 599) ? 599 : v;
    endfunction

    function automatic int ref_dec(int v);
        return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
    endfunction

    function automatic int next_rand();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return (lcg >> 8) & 12'hfff;
    endfunction

    // One sample; checks pixel after E+1 and digits/done after E+2 (R7, R8).
    task automatic run_sample(string req, int ax, int ay);
        int ex; int ey;
        ex = ref_x(ax);
        ey = ref_y(ay);
        @(negedge clk);
        adc_x = 12'(ax); adc_y = 12'(ay); sample_vld = 1'b1;
        @(negedge clk);              // E passed
        sample_vld = 1'b0;
        check({req, " done before digits R7"}, int'(dec_done), 0);
        @(negedge clk);              // E+1 passed
        check({req, " pix_x"}, int'(pix_x), ex);
        check({req, " pix_y"}, int'(pix_y), ey);
        @(negedge clk);              // E+2 passed
        check({req, " done R7"}, int'(dec_done), 1);
        check({req, " dec_x R8"}, int'(dec_x), ref_dec(ex));
        check({req, " dec_y R8"}, int'(dec_y), ref_dec(ey));
        @(negedge clk);
        check({req, " done pulse R7"}, int'(dec_done), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pix_x", int'(pix_x), 0);
        check("R1 pix_y", int'(pix_y), 0);
        check("R1 dec_x", int'(dec_x), 0);
        check("R1 dec_y", int'(dec_y), 0);
        check("R1 done", int'(dec_done), 0);
    endtask

    task automatic t_endpoints();
        run_sample("R4 low ends", 132, 3849);
        check("R4 x at 132", int'(pix_x), 0);
        check("R4 y at 3849", int'(pix_y), 0);
        run_sample("R4 high ends", 3946, 148);
        check("R4 x at 3946", int'(pix_x), 799);
        check("R4 y at 148", int'(pix_y), 599);
    endtask

    task automatic t_mapping();
        run_sample("R2 R3 mid", 2039, 1998);
        run_sample("R2 R3 quarter", 1085, 2923);
        run_sample("R3 inversion ref", 1000, 3000);
        begin
            int y_hi_read;
            y_hi_read = int'(pix_y);
            run_sample("R3 inversion", 1000, 1000);
            checks++;
            if (!(int'(pix_y) > y_hi_read)) begin
                failures++;
                $display("FAIL R3 inversion actual=%0d expected>%0d", pix_y, y_hi_read);
            end
        end
    endtask

    task automatic t_clamp();
        run_sample("R5 R6 below", 0, 0);
        check("R5 x below", int'(pix_x), 0);
        check("R6 y below", int'(pix_y), 599);
        run_sample("R5 R6 above", 4095, 4095);
        check("R5 x above", int'(pix_x), 799);
        check("R6 y above", int'(pix_y), 0);
        run_sample("R5 R6 just out", 131, 3850);
        run_sample("R5 R6 just in", 133, 3848);
    endtask

    task automatic t_random_ideal();
        for (int i = 0; i < 40; i++) begin
            int ax; int ay; int ox; int oy; int dx; int dy;
            ax = next_rand();
            ay = next_rand();
            run_sample("R2 R3 random", ax, ay);
            ox = ((ax < 132) ? 132 : (ax > 3946) ? 3946 : ax) - 132;
            oy = 3849 - ((ay < 148) ? 148 : (ay > 3849) ? 3849 : ay);
            dx = int'(pix_x) - (ox * 799) / 3814;
            dy = int'(pix_y) - (oy * 599) / 3701;
            checks++;
            if (dx < 0 || dx > 2 || dy < 0 || dy > 2) begin
                failures++;
                $display("FAIL R10 actual=%0d,%0d expected_ideal=%0d,%0d",
                         pix_x, pix_y, (ox * 799) / 3814, (oy * 599) / 3701);
            end
        end
    endtask

    task automatic t_hold();
        int px; int py; int dx; int dy;
        run_sample("R9 setup", 2500, 900);
        px = int'(pix_x); py = int'(pix_y); dx = int'(dec_x); dy = int'(dec_y);
        @(negedge clk);
        adc_x = 12'd300; adc_y = 12'd3500;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R9 pix_x held", int'(pix_x), px);
            check("R9 pix_y held", int'(pix_y), py);
            check("R9 dec_x held", int'(dec_x), dx);
            check("R9 dec_y held", int'(dec_y), dy);
            check("R9 no done", int'(dec_done), 0);
        end
    endtask

    task automatic t_back_to_back();
        int ax0 = 500;  int ay0 = 3200;
        int ax1 = 3300; int ay1 = 600;
        @(negedge clk);
        adc_x = 12'(ax0); adc_y = 12'(ay0); sample_vld = 1'b1;
        @(negedge clk);              // E0
        adc_x = 12'(ax1); adc_y = 12'(ay1);
        @(negedge clk);              // E1: first pixel
        sample_vld = 1'b0;
        check("R11 first pix_x", int'(pix_x), ref_x(ax0));
        check("R11 first pix_y", int'(pix_y), ref_y(ay0));
        @(negedge clk);              // E2: second pixel, first digits
        check("R11 second pix_x", int'(pix_x), ref_x(ax1));
        check("R11 second pix_y", int'(pix_y), ref_y(ay1));
        check("R11 first done", int'(dec_done), 1);
        check("R11 first dec_x", int'(dec_x), ref_dec(ref_x(ax0)));
        check("R11 first dec_y", int'(dec_y), ref_dec(ref_y(ay0)));
        @(negedge clk);              // E3: second digits
        check("R11 second done", int'(dec_done), 1);
        check("R11 second dec_x", int'(dec_x), ref_dec(ref_x(ax1)));
        check("R11 second dec_y", int'(dec_y), ref_dec(ref_y(ay1)));
        @(negedge clk);
        check("R11 done ends", int'(dec_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_endpoints();
        t_mapping();
        t_clamp();
        t_random_ideal();
        t_hold();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule